// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Decoder

This block is the control front end of an asynchronous-strobe DRAM, rebuilt as synchronous logic. It samples the active-low row strobe, column strobe, write enable and output enable on a fast system clock. From the order in which their edges arrive, it sorts every access into one of several types:

- a plain read
- an early write
- a late write
- a read-modify-write
- a row-only refresh
- a column-before-row refresh
- a hidden refresh, where read data stays on the pins across a refresh pulse

For each access it latches the row and column addresses and keeps its own refresh row counter. It drives strobes to a small storage stub and to a refresh port. It also decides when the data pins are driven and when they are high-impedance.

The block is a synthesizable stand-in for the memory when a DRAM controller is under test. Each recognised cycle type is reported as a single-cycle pulse on one bit of a one-hot event vector, so a checker can compare the sequence of operations against its expectation. Analog timing limits are not checked.

The strobes are resynchronised through two flops each. Any two strobe transitions must therefore be at least four clocks apart. The address and write data must be stable from a strobe change until four clocks after it.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, no event is pulsed, `dq_oe` is low, and the refresh row counter is 0, so the first counter-driven refresh reports row 0.
- R2: Once both the column strobe and the row strobe are high, `dq_oe` is low.
- R3: A falling row strobe while the column strobe is already low, with no read pending, pulses event bit 5. It also pulses `rfsh_stb` with `rfsh_row` equal to the internal counter, and the address pins are ignored. The counter then advances by one, modulo 2^ROW_W. `dq_oe` stays low throughout.
- R4: A falling row strobe with the column strobe high latches the row from `addr`. If the row strobe rises without any column strobe fall, event bit 4 and `rfsh_stb` pulse with `rfsh_row` equal to that latched row, and `dq_oe` stays low.
- R5: A column strobe fall inside an open row with write enable high pulses event bit 0 and reads the cell at index {row[CELL_RA-1:0], col[CELL_CA-1:0]}. That cell's data appears on `dq_out`, with `dq_oe` high while the column strobe and output enable are both low.
- R6: A write enable that is already low when the column strobe falls gives an early write. Event bit 1 pulses, `dq_in` is stored in the addressed cell, and `dq_oe` never rises during the cycle.
- R7: Write enable may fall after the column strobe, within the same column cycle, with output enable high the whole time. This is a late write: event bit 2 pulses (after the bit-0 pulse of the column fall), `dq_in` is stored, and `dq_oe` never rises.
- R8: Data may first be driven out (output enable low), then output enable is raised and write enable falls. This is a read-modify-write: event bit 3 pulses and `dq_in` replaces the cell contents.
- R9: With the column strobe held low after a read, the row strobe may rise and fall again. This is a hidden refresh: event bit 6 pulses (not bit 5), `rfsh_row` carries the counter, and the counter advances. `dq_oe` stays high with the earlier read data on `dq_out`.
- R10: Raising output enable while the column strobe is still low during a read drops `dq_oe`.
- R11: Within one open row, several column cycles each get their own read or write with a fresh column address, the row is kept, and no row-only refresh is reported at the row strobe rise.
- R12: At most one bit of `evt` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, at least 4x faster than the shortest strobe phase |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the controller |
| dq_out | output | DQ_W | Read data toward the pins |
| dq_oe | output | 1 | Pin driver enable; low means high-impedance |
| evt | output | 7 | One-hot cycle event pulse (bit 0 read, 1 early write, 2 late write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh) |
| mem_rd | output | 1 | Storage read strobe |
| mem_wr | output | 1 | Storage write strobe |
| rfsh_stb | output | 1 | Refresh-row strobe |
| rfsh_row | output | ROW_W | Row being refreshed |

## Verification
The bench goes after orderings that differ only in which strobe edge came first.

- **Column strobe already low at the row fall.** A decoder that missed this would latch the address bus and report a row-only refresh instead of taking the counter row.
- **Hidden refresh.** A decoder that cleared its read state on the row strobe rise would drop the pins or call the refresh an ordinary column-before-row cycle.
- **Late write versus read-modify-write.** These differ only in whether data was driven before write enable fell. Confusing them shows up as the wrong event bit.
- **Early write.** A decoder that briefly enabled the drivers here is caught by a monitor that watches `dq_oe` over the whole cycle.
- **Counter wrap and address capture edge.** The counter is run through a full wrap. The row address is changed just before the row strobe rises, which exposes a decoder that samples the row at the wrong edge.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  localparam int EV_W      = 7;
  localparam int EV_READ   = 0;
  localparam int EV_EARLY  = 1;
  localparam int EV_LATE   = 2;
  localparam int EV_RMW    = 3;
  localparam int EV_RONLY  = 4;
  localparam int EV_CBR    = 5;
  localparam int EV_HIDDEN = 6;

  typedef logic [EV_W-1:0] evt_t;
endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    logic stable;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/dcd_rfsh_ctr.sv
module dcd_rfsh_ctr #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/dcd_cell_stub.sv
module dcd_cell_stub #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) cells[idx] <= wdata;
    if (rd) rdata <= cells[idx];
  end
endmodule

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int CA_W  = 2,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_ras_n,
  input  logic             s_cas_n,
  input  logic             s_we_n,
  input  logic             s_oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DQ_W-1:0]  din,
  input  logic [ROW_W-1:0] ctr_row,
  output evt_t             evt,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             rfsh_stb,
  output logic [ROW_W-1:0] rfsh_row,
  output logic             ctr_adv,
  output logic [ROW_W-1:0] row_q,
  output logic [CA_W-1:0]  col_q,
  output logic [DQ_W-1:0]  wdata,
  output logic             dq_oe
);
  // asserted-polarity views of the synchronised strobes
  logic ras, cas, we, oe;
  assign ras = ~s_ras_n;
  assign cas = ~s_cas_n;
  assign we  = ~s_we_n;
  assign oe  = ~s_oe_n;

  logic ras_d, cas_d, we_d;
  logic row_open, col_seen, read_done, wrote, rd_seen;

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = ras & ~ras_d;
  assign ras_rise = ~ras & ras_d;
  assign cas_fall = cas & ~cas_d;
  assign cas_rise = ~cas & cas_d;
  assign we_fall  = we & ~we_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_d     <= 1'b0;
      cas_d     <= 1'b0;
      we_d      <= 1'b0;
      row_open  <= 1'b0;
      col_seen  <= 1'b0;
      read_done <= 1'b0;
      wrote     <= 1'b0;
      rd_seen   <= 1'b0;
      evt       <= '0;
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      rfsh_stb  <= 1'b0;
      rfsh_row  <= '0;
      ctr_adv   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      wdata     <= '0;
      dq_oe     <= 1'b0;
    end else begin
      ras_d    <= ras;
      cas_d    <= cas;
      we_d     <= we;
      evt      <= '0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      rfsh_stb <= 1'b0;
      ctr_adv  <= 1'b0;

      // row strobe falling: counter refresh if column already low, else open row
      if (ras_fall) begin
        if (cas_d) begin
          rfsh_stb <= 1'b1;
          rfsh_row <= ctr_row;
          ctr_adv  <= 1'b1;
          evt[read_done ? EV_HIDDEN : EV_CBR] <= 1'b1;
        end else begin
          row_q    <= addr;
          row_open <= 1'b1;
          col_seen <= 1'b0;
        end
      end

      // row strobe rising: a row never given a column is a row-only refresh
      if (ras_rise) begin
        if (row_open && !col_seen) begin
          rfsh_stb       <= 1'b1;
          rfsh_row       <= row_q;
          evt[EV_RONLY]  <= 1'b1;
        end
        row_open <= 1'b0;
      end

      // column strobe falling inside an open row
      if (cas_fall && ras && row_open) begin
        col_q    <= addr[CA_W-1:0];
        col_seen <= 1'b1;
        if (we) begin
          wr_stb        <= 1'b1;
          wdata         <= din;
          wrote         <= 1'b1;
          evt[EV_EARLY] <= 1'b1;
        end else begin
          rd_stb       <= 1'b1;
          read_done    <= 1'b1;
          evt[EV_READ] <= 1'b1;
        end
      end

      // write enable falling after the column strobe
      if (we_fall && !cas_fall && cas && ras && row_open && read_done && !wrote) begin
        wr_stb <= 1'b1;
        wdata  <= din;
        wrote  <= 1'b1;
        evt[rd_seen ? EV_RMW : EV_LATE] <= 1'b1;
      end

      if (read_done && dq_oe) rd_seen <= 1'b1;

      if (cas_rise) begin
        read_done <= 1'b0;
        wrote     <= 1'b0;
        rd_seen   <= 1'b0;
      end

      dq_oe <= read_done & cas & oe & ~wrote;
    end
  end
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int DQ_W    = 4,
  parameter int CELL_RA = 2,
  parameter int CELL_CA = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic [EV_W-1:0]  evt,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             rfsh_stb,
  output logic [ROW_W-1:0] rfsh_row
);
  localparam int CELL_AW = CELL_RA + CELL_CA;

  logic [3:0]         strobes_s;
  logic               s_ras_n, s_cas_n, s_we_n, s_oe_n;
  logic [ROW_W-1:0]   ctr_row;
  logic               ctr_adv;
  logic [ROW_W-1:0]   row_q;
  logic [CELL_CA-1:0] col_q;
  logic [DQ_W-1:0]    wdata;
  evt_t               evt_i;

  dcd_sync #(.W(4), .RST_VAL(4'b1111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({oe_n, we_n, cas_n, ras_n}),
    .q   (strobes_s)
  );
  assign {s_oe_n, s_we_n, s_cas_n, s_ras_n} = strobes_s;

  dcd_rfsh_ctr #(.ROW_W(ROW_W)) u_ctr (
    .clk (clk),
    .rst (rst),
    .adv (ctr_adv),
    .row (ctr_row)
  );

  dcd_ctrl #(.ROW_W(ROW_W), .CA_W(CELL_CA), .DQ_W(DQ_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .s_ras_n  (s_ras_n),
    .s_cas_n  (s_cas_n),
    .s_we_n   (s_we_n),
    .s_oe_n   (s_oe_n),
    .addr     (addr),
    .din      (dq_in),
    .ctr_row  (ctr_row),
    .evt      (evt_i),
    .rd_stb   (mem_rd),
    .wr_stb   (mem_wr),
    .rfsh_stb (rfsh_stb),
    .rfsh_row (rfsh_row),
    .ctr_adv  (ctr_adv),
    .row_q    (row_q),
    .col_q    (col_q),
    .wdata    (wdata),
    .dq_oe    (dq_oe)
  );
  assign evt = evt_i;

  dcd_cell_stub #(.AW(CELL_AW), .DW(DQ_W)) u_cells (
    .clk   (clk),
    .wr    (mem_wr),
    .rd    (mem_rd),
    .idx   ({row_q[CELL_RA-1:0], col_q}),
    .wdata (wdata),
    .rdata (dq_out)
  );
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dram_dec_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [EV_W-1:0]  evt,
  input logic             dq_oe,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             rfsh_stb,
  input logic [ROW_W-1:0] ctr_row,
  input logic             s_cas_n
);
  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt)); // R12

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11

  AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (rfsh_stb && (evt[EV_CBR] || evt[EV_HIDDEN])) |=> (ctr_row == ROW_W'($past(ctr_row) + 1'b1))); // R3

  AST_EARLY_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    evt[EV_EARLY] |-> (!dq_oe && !mem_rd)); // R6

  AST_HIZ_NO_CAS: assert property (@(posedge clk) disable iff (rst)
    $past(s_cas_n) |-> !dq_oe); // R2

  AST_RONLY_STROBE: assert property (@(posedge clk) disable iff (rst)
    evt[EV_RONLY] |-> (rfsh_stb && !dq_oe)); // R4
endmodule

bind dram_cycle_decoder dcd_checker #(.ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .evt      (evt),
  .dq_oe    (dq_oe),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .rfsh_stb (rfsh_stb),
  .ctr_row  (ctr_row),
  .s_cas_n  (s_cas_n)
);

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;
  localparam int ROW_W = 12;
  localparam int DQ_W  = 4;
  localparam int E_RD = 0, E_EW = 1, E_LW = 2, E_RMW = 3, E_RO = 4, E_CBR = 5, E_HID = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ROW_W-1:0] addr = '0;
  logic [DQ_W-1:0]  dq_in = '0;
  logic [DQ_W-1:0]  dq_out;
  logic             dq_oe;
  logic [6:0]       evt;
  logic             mem_rd, mem_wr, rfsh_stb;
  logic [ROW_W-1:0] rfsh_row;

  always #2 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .evt(evt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
  );

  int checks = 0;
  int errors = 0;
  int ev_cnt [7];
  int hot_err = 0;
  int oe_seen = 0;
  int rfsh_cnt = 0;
  logic [ROW_W-1:0] last_rrow = '0;
  logic [ROW_W-1:0] exp_ctr = '0;
  bit finished = 0;

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 7; i++) if (evt[i]) ev_cnt[i]++;
      if ($countones(evt) > 1) hot_err++;
      if (rfsh_stb) begin
        last_rrow = rfsh_row;
        rfsh_cnt++;
      end
      if (dq_oe) oe_seen = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 7; i++) ev_cnt[i] = 0;
    oe_seen  = 0;
    rfsh_cnt = 0;
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic ras_down(input logic [ROW_W-1:0] a);
    addr = a; ras_n = 1'b0; step();
  endtask

  task automatic cas_down(input logic [ROW_W-1:0] a);
    addr = a; cas_n = 1'b0; step();
  endtask

  task automatic close_all();
    cas_n = 1'b1; step();
    ras_n = 1'b1; step();
    we_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic t_reset();
    chk("R1 evt", evt, 0);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R2 idle hiz", dq_oe, 0);
  endtask

  task automatic t_cbr(input logic [ROW_W-1:0] junk);
    clr();
    cas_n = 1'b0; step();
    addr = junk; ras_n = 1'b0; step();
    ras_n = 1'b1; step();
    cas_n = 1'b1; step();
    chk("R3 cbr event", ev_cnt[E_CBR], 1);
    chk("R3 refresh row", last_rrow, exp_ctr);
    chk("R3 no drive", oe_seen, 0);
    exp_ctr = exp_ctr + 1'b1;
  endtask

  task automatic t_ras_only(input logic [ROW_W-1:0] row);
    clr();
    ras_down(row);
    addr = ~row; step();
    ras_n = 1'b1; step();
    chk("R4 ras-only event", ev_cnt[E_RO], 1);
    chk("R4 refresh row", last_rrow, row);
    chk("R4 no drive", oe_seen, 0);
  endtask

  task automatic t_early_write(input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] col,
                               input logic [DQ_W-1:0] d);
    clr();
    ras_down(row);
    we_n = 1'b0; dq_in = d; step();
    cas_down(col);
    close_all();
    chk("R6 early event", ev_cnt[E_EW], 1);
    chk("R6 no read event", ev_cnt[E_RD], 0);
    chk("R6 never drives", oe_seen, 0);
  endtask

  task automatic t_read(input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] col,
                        input logic [DQ_W-1:0] exp);
    clr();
    ras_down(row);
    oe_n = 1'b0;
    cas_down(col);
    chk("R5 read event", ev_cnt[E_RD], 1);
    chk("R5 dq_oe", dq_oe, 1);
    chk("R5 data", dq_out, exp);
    oe_n = 1'b1; step();
    chk("R10 oe high hiz", dq_oe, 0);
    close_all();
    chk("R2 closed hiz", dq_oe, 0);
  endtask

  task automatic t_fast_page();
    clr();
    ras_down(12'd1);
    we_n = 1'b0; dq_in = 4'h3; step();
    cas_down(12'd0);
    cas_n = 1'b1; we_n = 1'b1; step();
    oe_n = 1'b0;
    cas_down(12'd2);
    chk("R11 page read data", dq_out, 4'hA);
    chk("R11 page dq_oe", dq_oe, 1);
    close_all();
    chk("R11 page events", {ev_cnt[E_EW][7:0], ev_cnt[E_RD][7:0], ev_cnt[E_RO][7:0]}, 24'h010100);
    t_read(12'd1, 12'd0, 4'h3);
  endtask

  task automatic t_late_write();
    clr();
    ras_down(12'd2);
    cas_down(12'd3);
    dq_in = 4'h6; we_n = 1'b0; step();
    close_all();
    chk("R7 late event", ev_cnt[E_LW], 1);
    chk("R7 rmw not flagged", ev_cnt[E_RMW], 0);
    chk("R7 never drives", oe_seen, 0);
    t_read(12'd2, 12'd3, 4'h6);
  endtask

  task automatic t_rmw();
    t_early_write(12'd0, 12'd0, 4'h9);
    clr();
    ras_down(12'd0);
    oe_n = 1'b0;
    cas_down(12'd0);
    chk("R8 old data out", dq_out, 4'h9);
    oe_n = 1'b1; step();
    dq_in = 4'hC; we_n = 1'b0; step();
    chk("R8 outputs off in write", dq_oe, 0);
    close_all();
    chk("R8 rmw event", ev_cnt[E_RMW], 1);
    chk("R8 late not flagged", ev_cnt[E_LW], 0);
    t_read(12'd0, 12'd0, 4'hC);
  endtask

  task automatic t_hidden();
    clr();
    ras_down(12'd1);
    oe_n = 1'b0;
    cas_down(12'd2);
    ras_n = 1'b1; step();
    addr = 12'hFFF; ras_n = 1'b0; step();
    chk("R9 hidden event", ev_cnt[E_HID], 1);
    chk("R9 no plain cbr", ev_cnt[E_CBR], 0);
    chk("R9 refresh row", last_rrow, exp_ctr);
    chk("R9 still driving", dq_oe, 1);
    chk("R9 data kept", dq_out, 4'hA);
    exp_ctr = exp_ctr + 1'b1;
    close_all();
    chk("R2 after hidden", dq_oe, 0);
  endtask

  task automatic t_wrap();
    int n;
    n = (1 << ROW_W) - int'(exp_ctr);
    clr();
    for (int i = 0; i < n; i++) begin
      cas_n = 1'b0; repeat (5) @(negedge clk);
      ras_n = 1'b0; repeat (5) @(negedge clk);
      ras_n = 1'b1; repeat (5) @(negedge clk);
      cas_n = 1'b1; repeat (5) @(negedge clk);
    end
    chk("R3 wrap count", rfsh_cnt, n);
    exp_ctr = '0;
    t_cbr(12'h777);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_cbr(12'hABC);               // R1: first counter row is 0
    t_cbr(12'h123);
    t_ras_only(12'h5A3);
    t_early_write(12'd1, 12'd2, 4'hA);
    t_early_write(12'd3, 12'd1, 4'h5);
    t_read(12'd1, 12'd2, 4'hA);
    t_read(12'd3, 12'd1, 4'h5);
    t_fast_page();
    t_late_write();
    t_rmw();
    t_hidden();
    t_wrap();
    chk("R12 one-hot events", hot_err, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule